// File: doc/BRIEF.md
# CPU Register Extraction Sequencer

This block sits on the data path between a 65xx-style processor and its memory. It recovers the processor's programmer-visible registers without any help from the core. After a start request it waits for the next opcode fetch. From that cycle on it replaces memory data with a short, position-independent instruction stream: push flags, pull flags, store A to direct page, store X to an absolute address, store Y to direct page, and branch back. It then watches the bus cycles that the stream produces.

The stream's stores would corrupt memory, so every write cycle inside the stream raises a write-block output that gates the memory strobe. The addresses, bank byte and write data of those cycles are decoded into the program counter, stack pointer, flags, accumulator, index registers, data bank and direct page. The emulation, M and X status pins decide whether each store brings an upper byte. When the branch has returned the core to its original instruction, the block stops driving the bus and raises done. It then holds the values until the next start.

The block treats each clock as one processor bus cycle. Override data and write-block are combinational in the same cycle, so the core sees them in time.

Top module: `cpu_reg_snoop`

## Requirements
- R1: After reset, force_en, wr_block and done are 0 and every register result output is 0.
- R2: After start, override begins only on a cycle with cpu_vpa=1 and cpu_vda=1 (opcode fetch). Operand fetches (vpa=1, vda=0), data cycles and writes that come before it are neither overridden nor blocked.
- R3: From that first opcode fetch onward, each program-fetch cycle (cpu_vpa=1) gets the next stream byte on force_data with force_en=1. The bytes are 08, 28, 85, 02, 8E, 40, 44, 84, 06, 80, F5 (hex). The last byte is a branch offset of minus the stream length.
- R4: pc_out is {cpu_bank, cpu_addr} of the first overridden opcode fetch.
- R5: On the single write cycle of the flag push, sp_out takes cpu_addr and flags_out takes cpu_data_in.
- R6: On the first write cycle of the A, X and Y stores, the low byte of acc_out, x_out and y_out takes cpu_data_in.
- R7: The upper byte of acc_out is taken from the second store write only when cpu_emu=0 and cpu_mflag=0. The same holds for x_out and y_out with cpu_xflag=0. Otherwise the upper byte reads 0.
- R8: wr_block is 1 on every write cycle (cpu_rwn=0) from the first overridden fetch until release. It is 0 on writes outside the stream.
- R9: dbr_out is cpu_bank during the first X-store write. dpr_out is cpu_addr minus 2 during the first A-store write.
- R10: The first opcode fetch after the branch offset byte is not overridden. done is 1 from the next cycle on. While done is 1, results stay stable under any bus traffic. A new start drops done and clears the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an extraction (accepted when idle or done) |
| cpu_addr | input | ADDR_W | Processor address bus |
| cpu_bank | input | BANK_W | Processor bank address byte |
| cpu_data_in | input | DATA_W | Data driven by the processor on write cycles |
| cpu_rwn | input | 1 | 1 = read, 0 = write |
| cpu_vpa | input | 1 | Valid program address status |
| cpu_vda | input | 1 | Valid data address status |
| cpu_emu | input | 1 | Emulation mode status pin |
| cpu_mflag | input | 1 | Accumulator width status pin (1 = 8-bit) |
| cpu_xflag | input | 1 | Index width status pin (1 = 8-bit) |
| force_data | output | DATA_W | Substitute read data for the processor |
| force_en | output | 1 | Select force_data instead of memory data |
| wr_block | output | 1 | Suppress the memory write of this cycle |
| done | output | 1 | Extraction finished, results valid |
| pc_out | output | BANK_W+ADDR_W | Program bank and counter |
| sp_out | output | ADDR_W | Stack pointer |
| flags_out | output | DATA_W | Processor status flags |
| acc_out | output | 2*DATA_W | Accumulator |
| x_out | output | 2*DATA_W | X index |
| y_out | output | 2*DATA_W | Y index |
| dbr_out | output | BANK_W | Data bank |
| dpr_out | output | ADDR_W | Direct page base |

## Verification
A stream index that has slipped shows up in the same cycle as a wrong force_data byte on some program fetch. It can also show as force_en that is still high on the return fetch. A wrong instruction class or write ordinal goes unseen until done, when it shows as a swapped or mis-placed register byte. A wrong width flag shows then too, as a high byte that is present when it should be 0, or 0 when it should be present. Sequencer state that fails to leave the stream shows within a cycle as wr_block on a write outside the stream, or as done that never rises.

// File: rtl/regx_pkg.sv
package regx_pkg;

   localparam int STREAM_LEN = 11;
   localparam logic [7:0] BRA_OFF = 8'(256 - STREAM_LEN);

   typedef enum logic [2:0] {
      K_NONE, K_PHP, K_PLP, K_STA, K_STX, K_STY, K_BRA
   } ins_e;

   typedef enum logic [1:0] {
      S_IDLE, S_ARM, S_RUN, S_DONE
   } seq_e;

   function automatic logic [7:0] stream_byte(input logic [3:0] i,
                                              input logic [7:0] dpa,
                                              input logic [15:0] absx,
                                              input logic [7:0] dpy);
      case (i)
         4'd0:    stream_byte = 8'h08;
         4'd1:    stream_byte = 8'h28;
         4'd2:    stream_byte = 8'h85;
         4'd3:    stream_byte = dpa;
         4'd4:    stream_byte = 8'h8E;
         4'd5:    stream_byte = absx[7:0];
         4'd6:    stream_byte = absx[15:8];
         4'd7:    stream_byte = 8'h84;
         4'd8:    stream_byte = dpy;
         4'd9:    stream_byte = 8'h80;
         4'd10:   stream_byte = BRA_OFF;
         default: stream_byte = 8'hEA;
      endcase
   endfunction

   function automatic ins_e stream_class(input logic [3:0] i);
      case (i)
         4'd0:    stream_class = K_PHP;
         4'd1:    stream_class = K_PLP;
         4'd2:    stream_class = K_STA;
         4'd4:    stream_class = K_STX;
         4'd7:    stream_class = K_STY;
         4'd9:    stream_class = K_BRA;
         default: stream_class = K_NONE;
      endcase
   endfunction

endpackage

// File: rtl/regx_stream.sv
module regx_stream
   import regx_pkg::*;
#(
   parameter int          IDX_W = 4,
   parameter logic [7:0]  DP_A  = 8'h02,
   parameter logic [15:0] ABS_X = 16'h4440,
   parameter logic [7:0]  DP_Y  = 8'h06
) (
   input  logic [IDX_W-1:0] sel,
   input  logic             en,
   output logic [7:0]       byte_out,
   output ins_e             cls_out
);
   logic [3:0] sel4;

   assign sel4 = 4'(sel);

   always_comb begin
      if (en) begin
         byte_out = stream_byte(sel4, DP_A, ABS_X, DP_Y);
         cls_out  = stream_class(sel4);
      end else begin
         byte_out = 8'h00;
         cls_out  = K_NONE;
      end
   end
endmodule

// File: rtl/regx_seq.sv
module regx_seq
   import regx_pkg::*;
#(
   parameter int LEN   = STREAM_LEN,
   parameter int IDX_W = $clog2(LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             vpa,
   input  logic             vda,
   output logic [IDX_W-1:0] sel,
   output logic             force_on,
   output logic             first_take,
   output logic             active,
   output logic             clear,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN);

   seq_e             st;
   logic [IDX_W-1:0] idx;
   logic             op_fetch;
   logic             run_fetch;
   logic             release_now;

   assign op_fetch    = vpa & vda;
   assign first_take  = (st == S_ARM) & op_fetch;
   assign run_fetch   = (st == S_RUN) & vpa & (idx < LAST);
   assign release_now = (st == S_RUN) & op_fetch & (idx == LAST);
   assign force_on    = first_take | run_fetch;
   assign sel         = first_take ? '0 : idx;
   assign active      = first_take | ((st == S_RUN) & ~release_now);
   assign clear       = start & ((st == S_IDLE) | (st == S_DONE));
   assign done        = (st == S_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= S_IDLE;
         idx <= '0;
      end else begin
         case (st)
            S_IDLE, S_DONE: begin
               if (start) begin
                  st  <= S_ARM;
                  idx <= '0;
               end
            end
            S_ARM: begin
               if (op_fetch) begin
                  st  <= S_RUN;
                  idx <= IDX_W'(1);
               end
            end
            S_RUN: begin
               if (release_now) begin
                  st <= S_DONE;
               end else if (run_fetch) begin
                  idx <= idx + IDX_W'(1);
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/regx_capture.sv
module regx_capture
   import regx_pkg::*;
#(
   parameter int         ADDR_W = 16,
   parameter int         BANK_W = 8,
   parameter int         DATA_W = 8,
   parameter logic [7:0] DP_A   = 8'h02
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     active,
   input  logic                     first_take,
   input  logic                     op_forced,
   input  ins_e                     cls_in,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [BANK_W-1:0]        bank,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     rwn,
   input  logic                     emu,
   input  logic                     mflag,
   input  logic                     xflag,
   output logic [BANK_W+ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0]        sp_q,
   output logic [DATA_W-1:0]        flags_q,
   output logic [3*2*DATA_W-1:0]    lanes_q,
   output logic [BANK_W-1:0]        dbr_q,
   output logic [ADDR_W-1:0]        dpr_q
);
   ins_e       cls;
   logic [1:0] wcnt;
   logic       wr_cyc;
   logic       first_wr;

   assign wr_cyc   = active & ~rwn;
   assign first_wr = wr_cyc & (wcnt == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls  <= K_NONE;
         wcnt <= 2'd0;
      end else if (clear) begin
         cls  <= K_NONE;
         wcnt <= 2'd0;
      end else if (op_forced) begin
         cls  <= cls_in;
         wcnt <= 2'd0;
      end else if (wr_cyc && wcnt != 2'd3) begin
         wcnt <= wcnt + 2'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         sp_q    <= '0;
         flags_q <= '0;
         dbr_q   <= '0;
         dpr_q   <= '0;
      end else if (clear) begin
         pc_q    <= '0;
         sp_q    <= '0;
         flags_q <= '0;
         dbr_q   <= '0;
         dpr_q   <= '0;
      end else begin
         if (first_take) pc_q <= {bank, addr};
         if (first_wr && cls == K_PHP) begin
            sp_q    <= addr;
            flags_q <= wdata;
         end
         if (first_wr && cls == K_STA) dpr_q <= addr - ADDR_W'(DP_A);
         if (first_wr && cls == K_STX) dbr_q <= bank;
      end
   end

   for (genvar g = 0; g < 3; g++) begin : g_lane
      localparam ins_e LANE_K = (g == 0) ? K_STA : ((g == 1) ? K_STX : K_STY);
      logic [DATA_W-1:0] lo_q;
      logic [DATA_W-1:0] hi_q;
      logic              wide;
      logic              hit;

      assign hit  = (cls == LANE_K);
      assign wide = ~emu & ((g == 0) ? ~mflag : ~xflag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (clear) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_cyc && hit) begin
            if (wcnt == 2'd0) lo_q <= wdata;
            else if (wcnt == 2'd1 && wide) hi_q <= wdata;
         end
      end

      assign lanes_q[g*2*DATA_W +: 2*DATA_W] = {hi_q, lo_q};
   end
endmodule

// File: rtl/cpu_reg_snoop.sv
module cpu_reg_snoop
   import regx_pkg::*;
#(
   parameter int          ADDR_W = 16,
   parameter int          BANK_W = 8,
   parameter int          DATA_W = 8,
   parameter logic [7:0]  DP_A   = 8'h02,
   parameter logic [15:0] ABS_X  = 16'h4440,
   parameter logic [7:0]  DP_Y   = 8'h06
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic [BANK_W-1:0]        cpu_bank,
   input  logic [DATA_W-1:0]        cpu_data_in,
   input  logic                     cpu_rwn,
   input  logic                     cpu_vpa,
   input  logic                     cpu_vda,
   input  logic                     cpu_emu,
   input  logic                     cpu_mflag,
   input  logic                     cpu_xflag,
   output logic [DATA_W-1:0]        force_data,
   output logic                     force_en,
   output logic                     wr_block,
   output logic                     done,
   output logic [BANK_W+ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0]        sp_out,
   output logic [DATA_W-1:0]        flags_out,
   output logic [2*DATA_W-1:0]      acc_out,
   output logic [2*DATA_W-1:0]      x_out,
   output logic [2*DATA_W-1:0]      y_out,
   output logic [BANK_W-1:0]        dbr_out,
   output logic [ADDR_W-1:0]        dpr_out
);
   localparam int IDX_W = $clog2(STREAM_LEN + 1);
   localparam int REG_W = 2 * DATA_W;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("cpu_reg_snoop: DATA_W must be 8");
   end
   if (ADDR_W != 16) begin : g_bad_addr_w
      $error("cpu_reg_snoop: ADDR_W must be 16");
   end
   if (BANK_W < 1) begin : g_bad_bank_w
      $error("cpu_reg_snoop: BANK_W must be positive");
   end

   logic [IDX_W-1:0]   sel;
   logic               force_on;
   logic               first_take;
   logic               active;
   logic               clear;
   logic [7:0]         sbyte;
   ins_e               scls;
   logic [3*REG_W-1:0] lanes;

   regx_seq #(.LEN(STREAM_LEN), .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .vpa        (cpu_vpa),
      .vda        (cpu_vda),
      .sel        (sel),
      .force_on   (force_on),
      .first_take (first_take),
      .active     (active),
      .clear      (clear),
      .done       (done)
   );

   regx_stream #(.IDX_W(IDX_W), .DP_A(DP_A), .ABS_X(ABS_X), .DP_Y(DP_Y)) u_stream (
      .sel      (sel),
      .en       (force_on),
      .byte_out (sbyte),
      .cls_out  (scls)
   );

   regx_capture #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .DP_A(DP_A)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .active     (active),
      .first_take (first_take),
      .op_forced  (force_on & cpu_vda),
      .cls_in     (scls),
      .addr       (cpu_addr),
      .bank       (cpu_bank),
      .wdata      (cpu_data_in),
      .rwn        (cpu_rwn),
      .emu        (cpu_emu),
      .mflag      (cpu_mflag),
      .xflag      (cpu_xflag),
      .pc_q       (pc_out),
      .sp_q       (sp_out),
      .flags_q    (flags_out),
      .lanes_q    (lanes),
      .dbr_q      (dbr_out),
      .dpr_q      (dpr_out)
   );

   assign force_data = DATA_W'(sbyte);
   assign force_en   = force_on;
   assign wr_block   = active & ~cpu_rwn;
   assign acc_out    = lanes[0*REG_W +: REG_W];
   assign x_out      = lanes[1*REG_W +: REG_W];
   assign y_out      = lanes[2*REG_W +: REG_W];
endmodule

// File: rtl/regx_chk.sv
module regx_chk #(
   parameter int ADDR_W = 16,
   parameter int BANK_W = 8,
   parameter int DATA_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic                     cpu_rwn,
   input logic                     cpu_vpa,
   input logic                     cpu_vda,
   input logic                     force_en,
   input logic [DATA_W-1:0]        force_data,
   input logic                     wr_block,
   input logic                     done,
   input logic [BANK_W+ADDR_W-1:0] pc_out,
   input logic [2*DATA_W-1:0]      acc_out,
   input logic [2*DATA_W-1:0]      x_out,
   input logic [2*DATA_W-1:0]      y_out
);
   // R3: substitution only ever lands on a program-fetch cycle
   p_force_on_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      force_en |-> cpu_vpa);

   // R2: the push-flags opcode is only ever forced on an opcode fetch
   p_php_on_opfetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (force_en && force_data == DATA_W'(8'h08)) |-> (cpu_vpa && cpu_vda));

   // R8: blocking never hits a read cycle
   p_block_only_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_block |-> !cpu_rwn);

   // R10: once finished, the bus is left alone
   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!force_en && !wr_block));

   // R10: results and done hold until the next start
   p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(pc_out) && $stable(acc_out)
                            && $stable(x_out) && $stable(y_out)));

   // R10: done rises only after an unforced opcode fetch
   p_done_after_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(cpu_vpa && cpu_vda && !force_en));
endmodule

bind cpu_reg_snoop regx_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .cpu_rwn    (cpu_rwn),
   .cpu_vpa    (cpu_vpa),
   .cpu_vda    (cpu_vda),
   .force_en   (force_en),
   .force_data (force_data),
   .wr_block   (wr_block),
   .done       (done),
   .pc_out     (pc_out),
   .acc_out    (acc_out),
   .x_out      (x_out),
   .y_out      (y_out)
);

// File: tb/sim_cpu_reg_snoop.sv
module sim_cpu_reg_snoop;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_bank = '0;
   logic [7:0]  cpu_data_in = '0;
   logic        cpu_rwn = 1'b1;
   logic        cpu_vpa = 1'b0;
   logic        cpu_vda = 1'b0;
   logic        cpu_emu = 1'b1;
   logic        cpu_mflag = 1'b1;
   logic        cpu_xflag = 1'b1;
   logic [7:0]  force_data;
   logic        force_en;
   logic        wr_block;
   logic        done;
   logic [23:0] pc_out;
   logic [15:0] sp_out;
   logic [7:0]  flags_out;
   logic [15:0] acc_out;
   logic [15:0] x_out;
   logic [15:0] y_out;
   logic [7:0]  dbr_out;
   logic [15:0] dpr_out;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cpu_reg_snoop u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cpu_addr(cpu_addr), .cpu_bank(cpu_bank), .cpu_data_in(cpu_data_in),
      .cpu_rwn(cpu_rwn), .cpu_vpa(cpu_vpa), .cpu_vda(cpu_vda),
      .cpu_emu(cpu_emu), .cpu_mflag(cpu_mflag), .cpu_xflag(cpu_xflag),
      .force_data(force_data), .force_en(force_en), .wr_block(wr_block),
      .done(done), .pc_out(pc_out), .sp_out(sp_out), .flags_out(flags_out),
      .acc_out(acc_out), .x_out(x_out), .y_out(y_out),
      .dbr_out(dbr_out), .dpr_out(dpr_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bus cycle; combinational outputs checked mid-cycle
   task automatic cyc(input logic [15:0] a, input logic [7:0] b, input logic rw,
                      input logic vpa, input logic vda, input logic [7:0] wd,
                      input logic efe, input logic [7:0] efd, input logic ewb,
                      input string req);
      @(negedge clk);
      cpu_addr = a; cpu_bank = b; cpu_rwn = rw;
      cpu_vpa = vpa; cpu_vda = vda; cpu_data_in = wd;
      #1;
      chk({req, " force_en"}, 32'(force_en), 32'(efe));
      if (efe) chk({req, " force_data"}, 32'(force_data), 32'(efd));
      chk({req, " wr_block"}, 32'(wr_block), 32'(ewb));
   endtask

   task automatic pulse_start;
      @(negedge clk);
      start = 1'b1; cpu_vpa = 1'b0; cpu_vda = 1'b0; cpu_rwn = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic logic [15:0] exp_reg(input logic [15:0] v, input logic wide);
      return wide ? v : {8'h00, v[7:0]};
   endfunction

   task automatic run_seq(input logic [15:0] pc, input logic [7:0] pbr,
                          input logic [15:0] sp, input logic [7:0] fl,
                          input logic [15:0] ra, input logic [15:0] rx,
                          input logic [15:0] ry, input logic [15:0] dp,
                          input logic [7:0] dbr, input logic emu,
                          input logic m, input logic x);
      logic [15:0] spa;
      logic wa, wx;
      spa = emu ? {8'h01, sp[7:0]} : sp;
      wa = !emu && !m;
      wx = !emu && !x;
      cpu_emu = emu; cpu_mflag = m; cpu_xflag = x;
      pulse_start();
      chk("R10 done drops on start", 32'(done), 32'd0);
      // armed noise: no override, no block
      cyc(16'h1234, pbr, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R2 operand fetch while armed");
      cyc(16'h2000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R2 data read while armed");
      cyc(16'h2001, 8'h00, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, "R8 write before stream");
      // push flags
      cyc(pc, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h08, 1'b0, "R3 byte0");
      cyc(pc + 16'd1, pbr, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R3 php internal");
      cyc(spa, 8'h00, 1'b0, 1'b0, 1'b1, fl, 1'b0, 8'h00, 1'b1, "R8 php write");
      // pull flags
      cyc(pc + 16'd1, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h28, 1'b0, "R3 byte1");
      cyc(pc + 16'd2, pbr, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R3 plp int1");
      cyc(spa, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R3 plp int2");
      cyc(spa + 16'd1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R3 plp read");
      // store A direct
      cyc(pc + 16'd2, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h85, 1'b0, "R3 byte2");
      cyc(pc + 16'd3, pbr, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h02, 1'b0, "R3 byte3");
      cyc(dp + 16'd2, 8'h00, 1'b0, 1'b0, 1'b1, ra[7:0], 1'b0, 8'h00, 1'b1, "R8 sta low write");
      if (wa) cyc(dp + 16'd3, 8'h00, 1'b0, 1'b0, 1'b1, ra[15:8], 1'b0, 8'h00, 1'b1, "R8 sta high write");
      // store X absolute
      cyc(pc + 16'd4, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h8E, 1'b0, "R3 byte4");
      cyc(pc + 16'd5, pbr, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h40, 1'b0, "R3 byte5");
      cyc(pc + 16'd6, pbr, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h44, 1'b0, "R3 byte6");
      cyc(16'h4440, dbr, 1'b0, 1'b0, 1'b1, rx[7:0], 1'b0, 8'h00, 1'b1, "R8 stx low write");
      if (wx) cyc(16'h4441, dbr, 1'b0, 1'b0, 1'b1, rx[15:8], 1'b0, 8'h00, 1'b1, "R8 stx high write");
      // store Y direct
      cyc(pc + 16'd7, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h84, 1'b0, "R3 byte7");
      cyc(pc + 16'd8, pbr, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h06, 1'b0, "R3 byte8");
      cyc(dp + 16'd6, 8'h00, 1'b0, 1'b0, 1'b1, ry[7:0], 1'b0, 8'h00, 1'b1, "R8 sty low write");
      if (wx) cyc(dp + 16'd7, 8'h00, 1'b0, 1'b0, 1'b1, ry[15:8], 1'b0, 8'h00, 1'b1, "R8 sty high write");
      // branch back
      cyc(pc + 16'd9, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h80, 1'b0, "R3 byte9");
      cyc(pc + 16'd10, pbr, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hF5, 1'b0, "R3 byte10");
      cyc(pc + 16'd11, pbr, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R3 bra internal");
      chk("R10 done not before return", 32'(done), 32'd0);
      cyc(pc, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R10 return fetch unforced");
      @(negedge clk);
      cpu_vpa = 1'b0; cpu_vda = 1'b0; cpu_rwn = 1'b1;
      #1;
      chk("R10 done", 32'(done), 32'd1);
      chk("R4 pc", 32'(pc_out), 32'({pbr, pc}));
      chk("R5 sp", 32'(sp_out), 32'(spa));
      chk("R5 flags", 32'(flags_out), 32'(fl));
      chk("R6 R7 acc", 32'(acc_out), 32'(exp_reg(ra, wa)));
      chk("R6 R7 x", 32'(x_out), 32'(exp_reg(rx, wx)));
      chk("R6 R7 y", 32'(y_out), 32'(exp_reg(ry, wx)));
      chk("R9 dbr", 32'(dbr_out), 32'(dbr));
      chk("R9 dpr", 32'(dpr_out), 32'(dp));
      // post-done traffic must not touch anything
      cyc(pc + 16'd1, pbr, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R10 fetch after done");
      cyc(spa, 8'h00, 1'b0, 1'b0, 1'b1, ~fl, 1'b0, 8'h00, 1'b0, "R8 write after done");
      cyc(dp + 16'd2, 8'h00, 1'b0, 1'b0, 1'b1, ~ra[7:0], 1'b0, 8'h00, 1'b0, "R8 write after done 2");
      @(negedge clk);
      cpu_vpa = 1'b0; cpu_vda = 1'b0; cpu_rwn = 1'b1;
      #1;
      chk("R10 hold acc", 32'(acc_out), 32'(exp_reg(ra, wa)));
      chk("R10 hold flags", 32'(flags_out), 32'(fl));
      chk("R10 hold done", 32'(done), 32'd1);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      #1;
      // R1 reset state
      chk("R1 force_en", 32'(force_en), 32'd0);
      chk("R1 wr_block", 32'(wr_block), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 pc", 32'(pc_out), 32'd0);
      chk("R1 acc", 32'(acc_out), 32'd0);
      chk("R1 sp", 32'(sp_out), 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // idle: opcode fetch without start is not overridden (R2)
      cyc(16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R2 fetch without start");
      cyc(16'h0100, 8'h00, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 8'h00, 1'b0, "R8 idle write");
      // directed modes
      run_seq(16'hC000, 8'h00, 16'h01FF, 8'h34, 16'hAB12, 16'hCD34, 16'hEF56, 16'h0000, 8'h00, 1'b1, 1'b1, 1'b1);
      run_seq(16'h1234, 8'h7E, 16'h1FE0, 8'h05, 16'h9876, 16'h5432, 16'h1357, 16'h2400, 8'h3C, 1'b0, 1'b0, 1'b0);
      run_seq(16'h4000, 8'h01, 16'h0800, 8'h20, 16'hFF01, 16'h0202, 16'h0303, 16'h0010, 8'hA5, 1'b0, 1'b1, 1'b0);
      run_seq(16'hFFF8, 8'hFE, 16'h7FFF, 8'h10, 16'h1111, 16'h2222, 16'h3333, 16'hFF00, 8'h5A, 1'b0, 1'b0, 1'b1);
      // emulation mode with native-style flag pins low: still 8-bit (R7)
      run_seq(16'h0200, 8'h00, 16'h0140, 8'hFF, 16'h4455, 16'h6677, 16'h8899, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0);
      // random
      for (int k = 0; k < 8; k++) begin
         run_seq(16'($urandom), 8'($urandom), 16'($urandom), 8'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule